// File: doc/BRIEF.md
# Single-Entry Handshaked Channel Register

This block is a one-deep message slot between a producer and a consumer. It holds one data word, a valid flag (its occupancy count, zero or one) and a waiting flag. The waiting flag records that some party tried an access that could not complete: a push into a full slot or a pop from an empty one. Later operations that favour that party raise a one-cycle notify pulse so it can retry.

The producer side offers four push flavours, chosen by a mode field: a conditional push, an unconditional overwrite, an OR-merge into the stored word, and an AND-clear of selected bits. The consumer side offers a conditional pop that empties the slot and a keeping pop that returns the word but leaves it in place. A separate load port sets the word and the valid flag directly and never notifies. At most one operation is accepted per cycle. Results come back combinationally in the cycle of the request, and the state updates on the next rising clock edge.

Top module: `hs_chan_reg`

## Requirements
- R1: After reset, data_o is 0, count_o is 0, wait_o is 0 and notify_o is 0.
- R2: A push with push_mode_i = 0 (conditional) into an empty slot stores the word, sets count to 1, clears waiting and drives push_ok_o to 1. Into a full slot it drives push_ok_o to 0, keeps the data and count, and sets waiting.
- R3: A push with push_mode_i = 1 (overwrite) replaces the word, sets count to 1, clears waiting and drives push_ok_o to 1. It raises notify if waiting was set before the push.
- R4: A push with push_mode_i = 2 (OR-merge) ORs the word into the stored data, sets count to 1, clears waiting and drives push_ok_o to 1. It raises notify if waiting was set before.
- R5: A push with push_mode_i = 3 (AND-clear) clears the bits given in push_data_i from the stored data. It drives and_hit_o to 1 in the same cycle exactly when any of those bits was set, and leaves count and waiting unchanged.
- R6: A pop with pop_mode_i = 0 (conditional) from a full slot drives pop_ok_o to 1 and pop_data_o to the stored word, then clears the data, count and waiting, with no notify.
- R7: A conditional pop from an empty slot drives pop_ok_o and pop_data_o to 0, sets waiting and keeps the data.
- R8: A pop with pop_mode_i = 1 (keeping) drives pop_data_o to the stored word and pop_ok_o to the prior count. It keeps the data, clears count and waiting, and raises notify if waiting was set.
- R9: A load stores load_data_i, sets count to load_valid_i, clears waiting and never raises notify.
- R10: When several requests arrive together, load wins over push and push wins over pop. A losing request changes no state and gets all-zero results.
- R11: notify_o is a registered pulse, high for exactly the one cycle after the operation that caused it.
- R12: count_o is 1 exactly when the slot holds a valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_req_i | input | 1 | Direct load request |
| load_data_i | input | DW | Word for direct load |
| load_valid_i | input | 1 | Valid state written by a load |
| push_req_i | input | 1 | Push request |
| push_mode_i | input | 2 | 0 conditional, 1 overwrite, 2 OR-merge, 3 AND-clear |
| push_data_i | input | DW | Push word or clear mask |
| pop_req_i | input | 1 | Pop request |
| pop_mode_i | input | 1 | 0 conditional, 1 keeping |
| push_ok_o | output | 1 | Accepted push succeeded |
| and_hit_o | output | 1 | AND-clear found a set bit |
| pop_ok_o | output | 1 | Pop found a valid word |
| pop_data_o | output | DW | Word returned by a pop |
| count_o | output | 1 | Occupancy (0 or 1) |
| wait_o | output | 1 | Waiting flag |
| data_o | output | DW | Stored word |
| notify_o | output | 1 | One-cycle wake-up pulse |

## Verification
The bench targets the flag interplay. It checks that a failed conditional push leaves the word alone but arms waiting, and that the next overwrite or OR-merge turns that into exactly one notify pulse. A design that notified on every push, or held notify high, would show a second pulse. The keeping pop is read twice: the second read must return the same word with a zero ok flag, which catches a design that wipes the data. Simultaneous requests check that a lower-priority loser leaves no trace in the state or the result outputs. A load after a failed access checks that waiting is cleared without a notify.

// File: rtl/hs_chan_pkg.sv
package hs_chan_pkg;

  typedef enum logic [1:0] {
    PUSH_COND = 2'd0,
    PUSH_OVER = 2'd1,
    PUSH_OR   = 2'd2,
    PUSH_ANDC = 2'd3
  } push_mode_e;

  typedef enum logic {
    POP_COND = 1'b0,
    POP_KEEP = 1'b1
  } pop_mode_e;

  // request index doubles as priority rank (lower wins)
  localparam int unsigned OP_LOAD = 0;
  localparam int unsigned OP_PUSH = 1;
  localparam int unsigned OP_POP  = 2;
  localparam int unsigned OP_NUM  = 3;

endpackage

// File: rtl/hs_chan_arb.sv
module hs_chan_arb #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign gnt_o[i]   = req_i[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req_i[i];
  end

endmodule

// File: rtl/hs_chan_next.sv
module hs_chan_next
  import hs_chan_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [OP_NUM-1:0] gnt_i,
  input  logic [DW-1:0]     load_data_i,
  input  logic              load_valid_i,
  input  logic [1:0]        push_mode_i,
  input  logic [DW-1:0]     push_data_i,
  input  logic              pop_mode_i,
  input  logic [DW-1:0]     data_q_i,
  input  logic              valid_q_i,
  input  logic              wait_q_i,
  output logic [DW-1:0]     data_d_o,
  output logic              valid_d_o,
  output logic              wait_d_o,
  output logic              notify_d_o,
  output logic              push_ok_o,
  output logic              and_hit_o,
  output logic              pop_ok_o,
  output logic [DW-1:0]     pop_data_o
);
  push_mode_e pmode;
  pop_mode_e  qmode;

  assign pmode = push_mode_e'(push_mode_i);
  assign qmode = pop_mode_e'(pop_mode_i);

  always_comb begin
    data_d_o   = data_q_i;
    valid_d_o  = valid_q_i;
    wait_d_o   = wait_q_i;
    notify_d_o = 1'b0;
    push_ok_o  = 1'b0;
    and_hit_o  = 1'b0;
    pop_ok_o   = 1'b0;
    pop_data_o = '0;
    if (gnt_i[OP_LOAD]) begin
      data_d_o  = load_data_i;
      valid_d_o = load_valid_i;
      wait_d_o  = 1'b0;
    end else if (gnt_i[OP_PUSH]) begin
      unique case (pmode)
        PUSH_COND: begin
          if (valid_q_i) begin
            wait_d_o = 1'b1;
          end else begin
            data_d_o  = push_data_i;
            valid_d_o = 1'b1;
            wait_d_o  = 1'b0;
            push_ok_o = 1'b1;
          end
        end
        PUSH_OVER: begin
          data_d_o   = push_data_i;
          valid_d_o  = 1'b1;
          wait_d_o   = 1'b0;
          notify_d_o = wait_q_i;
          push_ok_o  = 1'b1;
        end
        PUSH_OR: begin
          data_d_o   = data_q_i | push_data_i;
          valid_d_o  = 1'b1;
          wait_d_o   = 1'b0;
          notify_d_o = wait_q_i;
          push_ok_o  = 1'b1;
        end
        default: begin
          data_d_o  = data_q_i & ~push_data_i;
          and_hit_o = |(data_q_i & push_data_i);
          push_ok_o = 1'b1;
        end
      endcase
    end else if (gnt_i[OP_POP]) begin
      if (qmode == POP_KEEP) begin
        pop_data_o = data_q_i;
        pop_ok_o   = valid_q_i;
        valid_d_o  = 1'b0;
        wait_d_o   = 1'b0;
        notify_d_o = wait_q_i;
      end else if (valid_q_i) begin
        pop_data_o = data_q_i;
        pop_ok_o   = 1'b1;
        data_d_o   = '0;
        valid_d_o  = 1'b0;
        wait_d_o   = 1'b0;
      end else begin
        wait_d_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hs_chan_state.sv
module hs_chan_state #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_d_i,
  input  logic          valid_d_i,
  input  logic          wait_d_i,
  input  logic          notify_d_i,
  output logic [DW-1:0] data_q_o,
  output logic          valid_q_o,
  output logic          wait_q_o,
  output logic          notify_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o   <= '0;
      valid_q_o  <= 1'b0;
      wait_q_o   <= 1'b0;
      notify_q_o <= 1'b0;
    end else begin
      data_q_o   <= data_d_i;
      valid_q_o  <= valid_d_i;
      wait_q_o   <= wait_d_i;
      notify_q_o <= notify_d_i;
    end
  end

endmodule

// File: rtl/hs_chan_reg.sv
module hs_chan_reg
  import hs_chan_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_req_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          load_valid_i,
  input  logic          push_req_i,
  input  logic [1:0]    push_mode_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_req_i,
  input  logic          pop_mode_i,
  output logic          push_ok_o,
  output logic          and_hit_o,
  output logic          pop_ok_o,
  output logic [DW-1:0] pop_data_o,
  output logic          count_o,
  output logic          wait_o,
  output logic [DW-1:0] data_o,
  output logic          notify_o
);
  logic [OP_NUM-1:0] req, gnt;
  logic [DW-1:0]     data_q, data_d;
  logic              valid_q, valid_d, wait_q, wait_d, notify_d;

  always_comb begin
    req          = '0;
    req[OP_LOAD] = load_req_i;
    req[OP_PUSH] = push_req_i;
    req[OP_POP]  = pop_req_i;
  end

  hs_chan_arb #(.N(OP_NUM)) u_arb (
    .req_i (req),
    .gnt_o (gnt)
  );

  hs_chan_next #(.DW(DW)) u_next (
    .gnt_i        (gnt),
    .load_data_i  (load_data_i),
    .load_valid_i (load_valid_i),
    .push_mode_i  (push_mode_i),
    .push_data_i  (push_data_i),
    .pop_mode_i   (pop_mode_i),
    .data_q_i     (data_q),
    .valid_q_i    (valid_q),
    .wait_q_i     (wait_q),
    .data_d_o     (data_d),
    .valid_d_o    (valid_d),
    .wait_d_o     (wait_d),
    .notify_d_o   (notify_d),
    .push_ok_o    (push_ok_o),
    .and_hit_o    (and_hit_o),
    .pop_ok_o     (pop_ok_o),
    .pop_data_o   (pop_data_o)
  );

  hs_chan_state #(.DW(DW)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_d_i   (data_d),
    .valid_d_i  (valid_d),
    .wait_d_i   (wait_d),
    .notify_d_i (notify_d),
    .data_q_o   (data_q),
    .valid_q_o  (valid_q),
    .wait_q_o   (wait_q),
    .notify_q_o (notify_o)
  );

  assign count_o = valid_q;
  assign wait_o  = wait_q;
  assign data_o  = data_q;

endmodule

// File: rtl/hs_chan_chk.sv
module hs_chan_chk
  import hs_chan_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_req_i,
  input logic [1:0]        push_mode_i,
  input logic              pop_mode_i,
  input logic [OP_NUM-1:0] gnt,
  input logic              count_o,
  input logic              wait_o,
  input logic [DW-1:0]     data_o,
  input logic              notify_o
);
  // R10
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));

  // R11
  notify_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> $past(wait_o));

  // R9
  load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_req_i |=> !notify_o);

  // R2
  push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt[OP_PUSH] && push_mode_i == PUSH_COND && count_o)
      |=> (wait_o && count_o && $stable(data_o)));

  // R3
  push_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt[OP_PUSH] && (push_mode_i == PUSH_OVER || push_mode_i == PUSH_OR) && wait_o)
      |=> notify_o);

  // R8
  keep_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt[OP_POP] && pop_mode_i == POP_KEEP) |=> (!count_o && !wait_o && $stable(data_o)));

endmodule

bind hs_chan_reg hs_chan_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_req_i  (load_req_i),
  .push_mode_i (push_mode_i),
  .pop_mode_i  (pop_mode_i),
  .gnt         (gnt),
  .count_o     (count_o),
  .wait_o      (wait_o),
  .data_o      (data_o),
  .notify_o    (notify_o)
);

// File: tb/hs_chan_reg_tb_top.sv
`timescale 1ns/1ps
module hs_chan_reg_tb_top;
  localparam int unsigned DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_req_i = 1'b0, load_valid_i = 1'b0;
  logic [DW-1:0] load_data_i = '0, push_data_i = '0;
  logic          push_req_i = 1'b0, pop_req_i = 1'b0, pop_mode_i = 1'b0;
  logic [1:0]    push_mode_i = '0;
  logic          push_ok_o, and_hit_o, pop_ok_o, count_o, wait_o, notify_o;
  logic [DW-1:0] pop_data_o, data_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // results captured during the request cycle
  logic          r_push_ok, r_and_hit, r_pop_ok;
  logic [DW-1:0] r_pop_data;

  always #2.5 clk_i = ~clk_i;

  hs_chan_reg #(.DW(DW)) dut_i (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic ld, input logic lv, input logic [DW-1:0] lwd,
                       input logic pu, input logic [1:0] pm, input logic [DW-1:0] pd,
                       input logic po, input logic qm);
    @(negedge clk_i);
    load_req_i = ld; load_valid_i = lv; load_data_i = lwd;
    push_req_i = pu; push_mode_i = pm; push_data_i = pd;
    pop_req_i = po; pop_mode_i = qm;
    #1;
    r_push_ok = push_ok_o; r_and_hit = and_hit_o;
    r_pop_ok = pop_ok_o; r_pop_data = pop_data_o;
    @(posedge clk_i);
    #1;
    load_req_i = 1'b0; push_req_i = 1'b0; pop_req_i = 1'b0;
  endtask

  task automatic push(input logic [1:0] m, input logic [DW-1:0] d);
    apply(1'b0, 1'b0, '0, 1'b1, m, d, 1'b0, 1'b0);
  endtask
  task automatic pop(input logic m);
    apply(1'b0, 1'b0, '0, 1'b0, 2'd0, '0, 1'b1, m);
  endtask
  task automatic load(input logic v, input logic [DW-1:0] d);
    apply(1'b1, v, d, 1'b0, 2'd0, '0, 1'b0, 1'b0);
  endtask
  task automatic idle();
    @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 data", data_o, 0);
    chk("R1 count", count_o, 0);
    chk("R12 count", count_o, 0);
    chk("R1 wait", wait_o, 0);
    chk("R1 notify", notify_o, 0);
  endtask

  task automatic t_cond_push();
    push(2'd0, 32'h0000_00A5);
    chk("R2 ok empty", r_push_ok, 1);
    chk("R2 data", data_o, 32'hA5);
    chk("R12 count", count_o, 1);
    chk("R2 wait", wait_o, 0);
    push(2'd0, 32'h0000_0011);
    chk("R2 ok full", r_push_ok, 0);
    chk("R2 data kept", data_o, 32'hA5);
    chk("R2 wait set", wait_o, 1);
    chk("R2 no notify", notify_o, 0);
  endtask

  task automatic t_overwrite();
    push(2'd1, 32'h0000_1234);
    chk("R3 ok", r_push_ok, 1);
    chk("R3 data", data_o, 32'h1234);
    chk("R3 wait", wait_o, 0);
    chk("R3 notify", notify_o, 1);
    idle();
    chk("R11 pulse end", notify_o, 0);
    push(2'd1, 32'h0000_1234);
    chk("R3 no notify", notify_o, 0);
  endtask

  task automatic t_or();
    push(2'd0, 32'h0);
    chk("R4 arm wait", wait_o, 1);
    push(2'd2, 32'h0F00_0000);
    chk("R4 data", data_o, 32'h0F00_1234);
    chk("R4 count", count_o, 1);
    chk("R4 wait", wait_o, 0);
    chk("R4 notify", notify_o, 1);
  endtask

  task automatic t_and();
    push(2'd3, 32'h0000_0030);
    chk("R5 hit", r_and_hit, 1);
    chk("R5 data", data_o, 32'h0F00_1204);
    chk("R5 count", count_o, 1);
    push(2'd3, 32'h0000_0008);
    chk("R5 miss", r_and_hit, 0);
    chk("R5 data kept", data_o, 32'h0F00_1204);
    chk("R5 wait", wait_o, 0);
  endtask

  task automatic t_cond_pop();
    pop(1'b0);
    chk("R6 ok", r_pop_ok, 1);
    chk("R6 pop data", r_pop_data, 32'h0F00_1204);
    chk("R6 data", data_o, 0);
    chk("R6 count", count_o, 0);
    chk("R6 notify", notify_o, 0);
    pop(1'b0);
    chk("R7 ok", r_pop_ok, 0);
    chk("R7 pop data", r_pop_data, 0);
    chk("R7 wait", wait_o, 1);
    chk("R7 data", data_o, 0);
  endtask

  task automatic t_keep_pop();
    push(2'd1, 32'h0000_CAFE);
    push(2'd0, 32'h1);
    chk("R8 arm wait", wait_o, 1);
    pop(1'b1);
    chk("R8 ok", r_pop_ok, 1);
    chk("R8 pop data", r_pop_data, 32'hCAFE);
    chk("R8 data kept", data_o, 32'hCAFE);
    chk("R8 count", count_o, 0);
    chk("R8 wait", wait_o, 0);
    chk("R8 notify", notify_o, 1);
    pop(1'b1);
    chk("R8 reread", r_pop_data, 32'hCAFE);
    chk("R8 ok empty", r_pop_ok, 0);
    chk("R8 no notify", notify_o, 0);
  endtask

  task automatic t_load();
    pop(1'b0);
    chk("R9 arm wait", wait_o, 1);
    load(1'b1, 32'h55);
    chk("R9 data", data_o, 32'h55);
    chk("R9 count", count_o, 1);
    chk("R9 wait", wait_o, 0);
    chk("R9 notify", notify_o, 0);
    load(1'b0, 32'h66);
    chk("R9 count off", count_o, 0);
    chk("R9 data2", data_o, 32'h66);
  endtask

  task automatic t_priority();
    apply(1'b1, 1'b1, 32'h77, 1'b1, 2'd1, 32'h99, 1'b1, 1'b0);
    chk("R10 push ignored", r_push_ok, 0);
    chk("R10 pop ignored", r_pop_ok, 0);
    chk("R10 data", data_o, 32'h77);
    chk("R10 count", count_o, 1);
    apply(1'b0, 1'b0, '0, 1'b1, 2'd0, 32'h88, 1'b1, 1'b0);
    chk("R10 push full", r_push_ok, 0);
    chk("R10 pop lost", r_pop_ok, 0);
    chk("R10 pop data", r_pop_data, 0);
    chk("R10 data kept", data_o, 32'h77);
    chk("R10 count kept", count_o, 1);
    chk("R10 wait", wait_o, 1);
  endtask

  initial begin
    #1;
    t_reset();
    #10;
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle();
    t_reset();
    t_cond_push();
    t_overwrite();
    t_or();
    t_and();
    t_cond_pop();
    t_keep_pop();
    t_load();
    t_priority();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule